// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block sends data words as asynchronous serial frames. Software writes a word into a single-entry holding register. A state machine moves that word into its shift register whenever the shifter is free and the start conditions hold. It then drives a frame on a line that idles high: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The frame carries 8 or 9 data bits. Frame settings are captured when a word is loaded, so changing them has no effect on a frame already being sent.

The bit period comes from a clock-source prescaler (divide by 1, 2, 8 or 32), a programmable divider n and a fixed 16x oversampling stage. A new frame starts only when transmit enable is high and the clear-to-send input is low. That input passes through a two-flop synchronizer. It is checked when the block is idle and again at the end of every final stop bit, so a high level holds the line idle between frames. A control input can switch the gating off. An interrupt request is raised either when the holding register empties or when transmission completes, and it stays set until it is acknowledged.

The state machine has five states. IDLE holds the line high. START, DATA and PARITY drive their bits. STOP drives the stop bits. The transitions are:
- IDLE→START on a load.
- START→DATA after one bit period.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after one bit period.
- STOP→START when the last stop bit ends and a load is allowed (back to back).
- STOP→IDLE when the last stop bit ends and no load is allowed.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, and whenever the shifter is idle, `txd` is 1. After reset, `buf_empty` is 1, `shift_empty` is 1 and `irq` is 0.
- R2: A frame is one start bit of 0, then the data bits with bit 0 first, then the parity bit if `parity_en` is 1, then the stop bits at 1. With `nine_bit`=0 the frame carries 8 data bits.
- R3: With `nine_bit`=1 the frame carries 9 data bits, and `wr_data[8]` follows bit 7.
- R4: The parity bit is the XOR of all the frame's data bits when `parity_odd`=0 (even parity). It is the inverse of that XOR when `parity_odd`=1 (odd parity).
- R5: With `two_stop`=1 the frame ends with two stop bits; with `two_stop`=0 it ends with one.
- R6: Every bit lasts 16·(`divider`+1)·P clock cycles. P is 1, 2, 8 or 32 for `clk_sel` values 0, 1, 2 and 3.
- R7: A write sets `buf_empty` to 0. `buf_empty` returns to 1 when the word moves into the shifter. A word that is waiting when the last stop bit ends starts its start bit in the very next bit period, with no idle gap.
- R8: `shift_empty` goes to 0 when a frame starts. It returns to 1 exactly frame-length × bit-period cycles later if no word is started at that point.
- R9: With `cts_disable`=0, no frame starts while `cts_n` is 1. This holds both in the idle state and at the end of the final stop bit. The waiting frame starts once `cts_n` is 0.
- R10: With `cts_disable`=1, `cts_n` has no effect, and frames start while it is held at 1.
- R11: While `tx_enable` is 0, no new frame starts and a written word stays in the holding register (`buf_empty`=0).
- R12: With `irq_on_done`=0, `irq` becomes 1 when a word moves into the shifter. It stays 1 until a cycle with `irq_ack`=1 clears it.
- R13: With `irq_on_done`=1, `irq` becomes 1 when the last stop bit ends and no new frame is started. It stays 0 while the frame is still being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit frames |
| tx_enable | input | 1 | Allows new frames to start |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| parity_en | input | 1 | Adds a parity bit after the data bits |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| cts_disable | input | 1 | 1 = ignore `cts_n` |
| clk_sel | input | 2 | Prescaler select: 0→/1, 1→/2, 2→/8, 3→/32 |
| divider | input | 8 | Divider value n |
| irq_on_done | input | 1 | 1 = interrupt on completion, 0 = interrupt on holding register empty |
| irq_ack | input | 1 | Clears the pending interrupt |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output |
| buf_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shifter is idle |
| irq | output | 1 | Pending interrupt request |

## Verification
The bench sends alternating data patterns at four rate settings. A wrong prescaler or divider count would move the sampling points off the bit centres and corrupt the data, and it would also change the measured time until `shift_empty` returns to 1. The bench checks parity in both senses over 8-bit and 9-bit words, which catches a parity tree that leaves out bit 8 or inverts the wrong way. It also checks the gap between two frames: the gap must be exactly one frame with gating off, and a pause of over a hundred cycles when `cts_n` rises during the first frame. A design that sampled the pin only when idle would send the second frame anyway, and one that dropped the last stop bit would measure short. Both interrupt triggers are checked for the cycle in which `irq` rises and for holding until acknowledged. A design that fired the completion interrupt between back-to-back frames, or cleared `irq` without an acknowledge, would fail these checks.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int WORD_W  = 9;
    localparam int PRE_MAX = 32;
    localparam int PRE_W   = $clog2(PRE_MAX);
    localparam int CNT_W   = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic two_stop;
    } frame_cfg_t;

    // last count of the prescaler for a given source select
    function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
        unique case (sel)
            2'd0: pre_last = PRE_W'(0);
            2'd1: pre_last = PRE_W'(1);
            2'd2: pre_last = PRE_W'(7);
            default: pre_last = PRE_W'(PRE_MAX - 1);
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_sync.sv
module uart_tx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
    import uart_tx_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] divider,
    output logic             bit_tick
);
    localparam int OS_W = $clog2(OVERSAMPLE);

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [OS_W-1:0]  os_cnt;
    logic             pre_wrap, div_wrap, os_wrap;

    always_comb begin
        pre_wrap = (pre_cnt == pre_last(clk_sel));
        div_wrap = pre_wrap && (div_cnt == divider);
        os_wrap  = div_wrap && (os_cnt == OS_W'(OVERSAMPLE - 1));
        bit_tick = run && os_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            os_cnt  <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            os_cnt  <= '0;
        end else begin
            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
            if (pre_wrap) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
            if (div_wrap) os_cnt  <= os_wrap  ? '0 : os_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] data,
    output logic         full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
        end else begin
            if (wr_en) data <= wr_data;
            if (wr_en)     full <= 1'b1;
            else if (take) full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
    import uart_tx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              nine_bit,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              cts_disable,
    input  logic [1:0]        clk_sel,
    input  logic [DIV_W-1:0]  divider,
    input  logic              irq_on_done,
    input  logic              irq_ack,
    input  logic              cts_n,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq
);
    tx_state_e         state, next_state;
    frame_cfg_t        cfg;
    logic [WORD_W-1:0] shreg, hold_data, masked;
    logic [CNT_W-1:0]  bit_cnt;
    logic              stop_cnt, par_bit;
    logic              hold_full, cts_s, tick;
    logic              can_start, last_data, last_stop, stop_end;
    logic              load_frame, frame_done;

    uart_tx_hold #(.W(WORD_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .take(load_frame), .data(hold_data), .full(hold_full)
    );

    uart_tx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s)
    );

    uart_tx_baud #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) i_baud (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
        .clk_sel(clk_sel), .divider(divider), .bit_tick(tick)
    );

    // start conditions and frame boundaries
    always_comb begin
        can_start  = hold_full && tx_enable && (cts_disable || !cts_s);
        last_data  = (bit_cnt == CNT_W'(cfg.nine ? WORD_W - 1 : WORD_W - 2));
        last_stop  = !cfg.two_stop || stop_cnt;
        stop_end   = (state == ST_STOP) && tick && last_stop;
        load_frame = can_start && ((state == ST_IDLE) || stop_end);
        frame_done = stop_end && !can_start;
        masked     = nine_bit ? hold_data : {1'b0, hold_data[WORD_W-2:0]};
    end

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   if (can_start) next_state = ST_START;
            ST_START:  if (tick) next_state = ST_DATA;
            ST_DATA:   if (tick && last_data)
                           next_state = cfg.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick) next_state = ST_STOP;
            ST_STOP:   if (stop_end)
                           next_state = can_start ? ST_START : ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // shift path and frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
            par_bit  <= 1'b0;
            cfg      <= '0;
        end else if (load_frame) begin
            shreg    <= hold_data;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
            par_bit  <= (^masked) ^ parity_odd;
            cfg      <= '{nine: nine_bit, par_en: parity_en, two_stop: two_stop};
        end else if (tick) begin
            if (state == ST_DATA) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_STOP) stop_cnt <= 1'b1;
        end
    end

    // interrupt request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     irq <= 1'b0;
        else if (irq_on_done ? frame_done : load_frame) irq <= 1'b1;
        else if (irq_ack)                               irq <= 1'b0;
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
        shift_empty = (state == ST_IDLE);
        buf_empty   = !hold_full;
    end
endmodule

// File: rtl/uart_tx_cts_checker.sv
module uart_tx_cts_checker (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic shift_empty,
    input logic buf_empty,
    input logic irq,
    input logic irq_ack,
    input logic cts_n,
    input logic cts_disable,
    input logic tx_enable
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);

    assert_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !shift_empty);

    assert_cts_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shift_empty) && !$past(cts_disable)) |-> !$past(cts_n, 3));

    assert_enable_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(tx_enable));

    assert_irq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
endmodule

bind uart_tx_cts uart_tx_cts_checker i_checker (
    .clk(clk), .rst_n(rst_n), .txd(txd), .shift_empty(shift_empty),
    .buf_empty(buf_empty), .irq(irq), .irq_ack(irq_ack), .cts_n(cts_n),
    .cts_disable(cts_disable), .tx_enable(tx_enable)
);

// File: tb/test_uart_tx_cts.sv
module test_uart_tx_cts;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_enable = 1'b1, nine_bit = 1'b0, parity_en = 1'b0;
    logic       parity_odd = 1'b0, two_stop = 1'b0, cts_disable = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [7:0] divider = 8'd0;
    logic       irq_on_done = 1'b0, irq_ack = 1'b0, cts_n = 1'b0;
    logic       txd, buf_empty, shift_empty, irq;

    uart_tx_cts i_uart_tx_cts (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .nine_bit(nine_bit), .parity_en(parity_en),
        .parity_odd(parity_odd), .two_stop(two_stop), .cts_disable(cts_disable),
        .clk_sel(clk_sel), .divider(divider), .irq_on_done(irq_on_done),
        .irq_ack(irq_ack), .cts_n(cts_n), .txd(txd), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [12:0] bits;
        int          nbits;
        int          period;
        string       req;
    } frame_t;

    frame_t exp_q[$];
    int     start_t[$];
    int     checks = 0, fails = 0, cyc = 0;
    bit     mon_busy = 1'b0, finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int bit_period();
        int p;
        p = (clk_sel == 2'd0) ? 1 : (clk_sel == 2'd1) ? 2 : (clk_sel == 2'd2) ? 8 : 32;
        return 16 * (int'(divider) + 1) * p;
    endfunction

    // driver: builds the expected frame, queues it, writes the word
    task automatic send(input logic [8:0] d, input string req);
        frame_t f;
        int     n, nd;
        logic   x;
        f.bits = '0;
        nd = nine_bit ? 9 : 8;
        n = 1;
        x = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f.bits[n] = d[i];
            x = x ^ d[i];
            n++;
        end
        if (parity_en) begin
            f.bits[n] = x ^ parity_odd;
            n++;
        end
        f.bits[n] = 1'b1;
        n++;
        if (two_stop) begin
            f.bits[n] = 1'b1;
            n++;
        end
        f.nbits = n;
        f.period = bit_period();
        f.req = req;
        exp_q.push_back(f);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: samples each bit at its centre and compares with the queue
    initial begin
        bit prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev && txd === 1'b0) begin
                frame_t      f;
                logic [12:0] got;
                mon_busy = 1'b1;
                start_t.push_back(cyc);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected frame", 0, 1);
                end else begin
                    f = exp_q.pop_front();
                    got = '0;
                    repeat (f.period / 2) @(negedge clk);
                    got[0] = txd;
                    for (int i = 1; i < f.nbits; i++) begin
                        repeat (f.period) @(negedge clk);
                        got[i] = txd;
                    end
                    check(got == f.bits, f.req, int'(got), int'(f.bits));
                end
                mon_busy = 1'b0;
            end
            prev = txd;
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (!(shift_empty && buf_empty && !mon_busy && exp_q.size() == 0));
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // single frame, measuring the time until the shifter reports empty (R8)
    task automatic timed_frame(input logic [8:0] d, input int nbits, input string req);
        int t0;
        send(d, req);
        do @(negedge clk); while (!mon_busy);
        t0 = start_t[$];
        do @(negedge clk); while (!shift_empty);
        check(cyc - t0 == nbits * bit_period(), "R8 shift_empty timing",
              cyc - t0, nbits * bit_period());
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int t_a, gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd && buf_empty && shift_empty && !irq, "R1 reset state",
              {txd, buf_empty, shift_empty, irq}, 4'b1110);
        repeat (4) @(negedge clk);

        // R2 basic 8-bit frames
        send(9'h0A5, "R2 8N1 A5");
        wait_idle();
        timed_frame(9'h03C, 10, "R2 8N1 3C");
        check(txd, "R1 idle line high", txd, 1);

        // R4 parity both senses
        parity_en = 1'b1;
        send(9'h05A, "R4 even parity 5A");
        wait_idle();
        parity_odd = 1'b1;
        send(9'h05A, "R4 odd parity 5A");
        wait_idle();
        send(9'h0F7, "R4 odd parity F7");
        wait_idle();

        // R3 and R5: nine bits, two stop bits
        parity_en = 1'b0;
        nine_bit = 1'b1;
        two_stop = 1'b1;
        timed_frame(9'h155, 12, "R3 R5 9N2 155");
        parity_en = 1'b1;
        parity_odd = 1'b0;
        send(9'h1C3, "R3 R4 9E2 1C3");
        wait_idle();
        nine_bit = 1'b0;
        parity_en = 1'b0;
        two_stop = 1'b0;

        // R6 rate settings
        clk_sel = 2'd1; divider = 8'd1;
        timed_frame(9'h055, 10, "R6 sel1 div1");
        clk_sel = 2'd3; divider = 8'd0;
        timed_frame(9'h0AA, 10, "R6 sel3 div0");
        clk_sel = 2'd2; divider = 8'd2;
        timed_frame(9'h033, 10, "R6 sel2 div2");
        clk_sel = 2'd0; divider = 8'd0;

        // R7 and R10: back to back with gating off and pin high
        cts_disable = 1'b1;
        cts_n = 1'b1;
        send(9'h011, "R10 pin ignored first");
        do @(negedge clk); while (!buf_empty);
        send(9'h0EE, "R7 back to back second");
        check(!buf_empty, "R7 buf_empty after write", buf_empty, 0);
        wait_idle();
        gap = start_t[$] - start_t[$-1];
        check(gap == 10 * bit_period(), "R7 no idle gap", gap, 10 * bit_period());

        // R9 gating while idle
        cts_disable = 1'b0;
        send(9'h069, "R9 released frame");
        repeat (200) @(negedge clk);
        check(txd && shift_empty && !buf_empty, "R9 blocked while idle",
              {txd, shift_empty, buf_empty}, 3'b110);
        cts_n = 1'b0;
        wait_idle();

        // R9 gating at the end of the stop bit
        send(9'h081, "R9 first of pair");
        do @(negedge clk); while (!buf_empty);
        t_a = start_t[$];
        send(9'h07E, "R9 second of pair");
        cts_n = 1'b1;
        do @(negedge clk); while (!shift_empty);
        repeat (100) @(negedge clk);
        check(shift_empty && !buf_empty && txd && start_t[$] == t_a,
              "R9 paused at stop", {shift_empty, buf_empty, txd}, 3'b101);
        cts_n = 1'b0;
        wait_idle();
        gap = start_t[$] - t_a;
        check(gap > 10 * bit_period() + 100, "R9 gap length", gap, 10 * bit_period() + 100);

        // R11 transmit enable
        tx_enable = 1'b0;
        send(9'h0C6, "R11 frame after enable");
        repeat (300) @(negedge clk);
        check(txd && shift_empty && !buf_empty, "R11 held while disabled",
              {txd, shift_empty, buf_empty}, 3'b110);
        tx_enable = 1'b1;
        wait_idle();

        // R12 interrupt on holding register empty
        irq_on_done = 1'b0;
        pulse_ack();
        check(!irq, "R12 ack clears", irq, 0);
        send(9'h0B4, "R12 frame");
        repeat (3) @(negedge clk);
        check(irq && !shift_empty, "R12 raised on load", {irq, shift_empty}, 2'b10);
        repeat (50) @(negedge clk);
        check(irq, "R12 stays pending", irq, 1);
        pulse_ack();
        check(!irq, "R12 cleared by ack", irq, 0);
        wait_idle();

        // R13 interrupt on completion
        irq_on_done = 1'b1;
        pulse_ack();
        send(9'h04D, "R13 frame");
        repeat (80) @(negedge clk);
        check(!irq && !shift_empty, "R13 quiet mid frame", {irq, shift_empty}, 2'b00);
        do @(negedge clk); while (!shift_empty);
        check(irq, "R13 raised at completion", irq, 1);
        wait_idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule